// File: doc/BRIEF.md
# Key-Protected Host Controller Register Bank

This block is a small memory-mapped register bank for the host side of a PCIe controller. It has 64 words of 32 bits in a 256-byte window. Reset loads fixed identity, class, data-link and link-status words, and every other word resets to zero. The bank is written and read over a plain synchronous register bus with an address, a write strobe, write data and registered read data.

One word acts as a write guard. Software unlocks the bank by writing a fixed key byte into that word. The guard word does not store the value written. It keeps a single flag, which reads back as 1 when the bank is unlocked and 0 when it is locked. While the bank is locked, writes to every other word are dropped. Writes to the guard word itself are always accepted, so software can lock the bank again by writing any other byte.

Top module: `hc_keyreg_top`

## Requirements
- R1: After reset, word 0x00 reads {16'h1150, VENDOR_ID}, word 0x04 reads 32'h06040006, word 0x10 reads 32'hD7040022 and word 0xC0 reads 32'h00000020 (bit 5 is link up). Every other word reads zero.
- R2: A write to byte offset 0x7C examines only bits 7:0 of the write data. If that byte is 8'hA8, later reads of 0x7C return 32'h1. Any other byte makes later reads return 32'h0. Bits 31:1 of a 0x7C read are always zero.
- R3: The bank is locked after reset (0x7C reads 0). While it is locked, writes to any offset other than 0x7C leave the stored word unchanged.
- R4: While the bank is unlocked, a write to any offset other than 0x7C stores the full 32-bit data word. The word is selected by address bits 7:2, and address bits 1:0 are ignored.
- R5: Read data is registered. On the clock edge after an address is presented, rdata shows the word at that address as it was before that edge, so a read in the same cycle as a write to the same word returns the old value.
- R6: While reset is asserted, rdata is zero. A reset in the middle of operation restores all reset values and locks the bank again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (8) | Byte address; bits 7:2 select the word |
| we | input | 1 | Write strobe for the current cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous cycle's address |

## Verification
The hardest case to reach is a write that is dropped because the bank is locked. A dropped write is only visible if it is followed by a read of the same word, and that read must show the old contents. The stimulus first writes a word while the bank is locked and reads it back. It then unlocks the bank, stores a known pattern and locks the bank again with a wrong key, so that a second dropped write has a non-zero value it could have overwritten. The same-cycle read and write case, and the return to the locked state after a reset in the middle of a run, are reached by directed steps after the vector table.

// File: rtl/hc_keyreg_pkg.sv
package hc_keyreg_pkg;
  localparam int WORD_W     = 32;
  localparam int IDX_ID     = 0;   // 0x00
  localparam int IDX_CLASS  = 1;   // 0x04
  localparam int IDX_LINK_D = 4;   // 0x10
  localparam int IDX_GUARD  = 31;  // 0x7C
  localparam int IDX_LINK_S = 48;  // 0xC0
  localparam logic [15:0] DEV_CODE  = 16'h1150;
  localparam logic [31:0] CLASS_RST = 32'h0604_0006;
  localparam logic [31:0] LINKD_RST = 32'hD704_0022;
  localparam int LINK_UP_BIT = 5;

  function automatic logic [WORD_W-1:0] rst_word(input int idx, input logic [15:0] vendor);
    logic [WORD_W-1:0] v;
    v = '0;
    case (idx)
      IDX_ID:     v = {DEV_CODE, vendor};
      IDX_CLASS:  v = CLASS_RST;
      IDX_LINK_D: v = LINKD_RST;
      IDX_LINK_S: v[LINK_UP_BIT] = 1'b1;
      default:    v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/hc_key_guard.sv
module hc_key_guard #(
  parameter int          KEY_W = 8,
  parameter logic [7:0]  KEY   = 8'hA8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_guard,
  input  logic [KEY_W-1:0] key_byte,
  output logic             unlocked
);
  always_ff @(posedge clk) begin
    if (rst)           unlocked <= 1'b0;
    else if (wr_guard) unlocked <= (key_byte == KEY[KEY_W-1:0]);
  end

  // R2
  key_decode_chk: assert property (@(posedge clk) disable iff (rst)
    wr_guard |=> (unlocked == ($past(key_byte) == KEY[KEY_W-1:0])));

  // R2
  guard_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_guard |=> $stable(unlocked));

  // R3
  reset_locked_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !unlocked);
endmodule

// File: rtl/hc_reg_bank.sv
module hc_reg_bank
  import hc_keyreg_pkg::*;
#(
  parameter int          IDX_W     = 6,
  parameter logic [15:0] VENDOR_ID = 16'h1A03,
  localparam int         NUM_WORDS = 2 ** IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              wr_ok,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] words [NUM_WORDS]
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    if (g == IDX_GUARD) begin : g_guard_slot
      assign words[g] = '0;
    end else begin : g_store
      logic hit;
      assign hit = we && wr_ok && (idx == IDX_W'(g));
      always_ff @(posedge clk) begin
        if (rst)      words[g] <= rst_word(g, VENDOR_ID);
        else if (hit) words[g] <= wdata;
      end

      // R3
      locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_ok |=> $stable(words[g]));

      // R4
      store_chk: assert property (@(posedge clk) disable iff (rst)
        (we && wr_ok && idx == IDX_W'(g)) |=> (words[g] == $past(wdata)));
    end
  end
endmodule

// File: rtl/hc_rd_port.sv
module hc_rd_port
  import hc_keyreg_pkg::*;
#(
  parameter int  IDX_W     = 6,
  localparam int NUM_WORDS = 2 ** IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic              unlocked,
  input  logic [WORD_W-1:0] words [NUM_WORDS],
  output logic [WORD_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)                          rdata <= '0;
    else if (idx == IDX_W'(IDX_GUARD)) rdata <= {{(WORD_W-1){1'b0}}, unlocked};
    else                              rdata <= words[idx];
  end

  // R2
  guard_read_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(idx) == IDX_W'(IDX_GUARD)) |-> (rdata[WORD_W-1:1] == '0));

  // R6
  rst_rdata_chk: assert property (@(posedge clk)
    $past(rst) |-> (rdata == '0));
endmodule

// File: rtl/hc_keyreg_top.sv
module hc_keyreg_top
  import hc_keyreg_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [15:0] VENDOR_ID = 16'h1A03,
  parameter logic [7:0]  KEY       = 8'hA8,
  localparam int         IDX_W     = ADDR_W - 2,
  localparam int         NUM_WORDS = 2 ** IDX_W,
  localparam int         KEY_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [IDX_W-1:0]  idx;
  logic              unlocked;
  logic              wr_guard;
  logic              unused_low_addr;
  logic [WORD_W-1:0] words [NUM_WORDS];

  assign idx             = addr[ADDR_W-1:2];
  assign unused_low_addr = &{1'b0, addr[1:0]};
  assign wr_guard        = we && (idx == IDX_W'(IDX_GUARD));

  hc_key_guard #(.KEY_W(KEY_W), .KEY(KEY)) i_guard (
    .clk      (clk),
    .rst      (rst),
    .wr_guard (wr_guard),
    .key_byte (wdata[KEY_W-1:0]),
    .unlocked (unlocked)
  );

  hc_reg_bank #(.IDX_W(IDX_W), .VENDOR_ID(VENDOR_ID)) i_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .wr_ok (unlocked),
    .idx   (idx),
    .wdata (wdata),
    .words (words)
  );

  hc_rd_port #(.IDX_W(IDX_W)) i_rd (
    .clk      (clk),
    .rst      (rst),
    .idx      (idx),
    .unlocked (unlocked),
    .words    (words),
    .rdata    (rdata)
  );
endmodule

// File: tb/test_hc_keyreg_top.sv
module test_hc_keyreg_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] VEND       = 16'h1A03;
  localparam logic [31:0] ID_RST     = {16'h1150, VEND};
  localparam int          NV         = 25;
  // entry: {addr[8], we, wdata[32], expected read[32]}
  localparam logic [72:0] VEC [NV] = '{
    {8'h00, 1'b0, 32'h0,         ID_RST},        // R1
    {8'h04, 1'b0, 32'h0,         32'h06040006},  // R1
    {8'h10, 1'b0, 32'h0,         32'hD7040022},  // R1
    {8'hC0, 1'b0, 32'h0,         32'h00000020},  // R1
    {8'h7C, 1'b0, 32'h0,         32'h0},         // R3 locked
    {8'h08, 1'b0, 32'h0,         32'h0},         // R1
    {8'h08, 1'b1, 32'hDEADBEEF,  32'h0},
    {8'h08, 1'b0, 32'h0,         32'h0},         // R3 ignored
    {8'h7C, 1'b1, 32'h000000A8,  32'h0},
    {8'h7C, 1'b0, 32'h0,         32'h1},         // R2 unlock
    {8'h08, 1'b1, 32'hDEADBEEF,  32'h0},
    {8'h08, 1'b0, 32'h0,         32'hDEADBEEF},  // R4
    {8'h00, 1'b1, 32'h12345678,  32'h0},
    {8'h00, 1'b0, 32'h0,         32'h12345678},  // R4
    {8'h7C, 1'b1, 32'hFFFFFFA7,  32'h0},
    {8'h7C, 1'b0, 32'h0,         32'h0},         // R2 wrong key
    {8'h08, 1'b1, 32'h0,         32'h0},
    {8'h08, 1'b0, 32'h0,         32'hDEADBEEF},  // R3 relock holds
    {8'h7C, 1'b1, 32'h123456A8,  32'h0},
    {8'h7C, 1'b0, 32'h0,         32'h1},         // R2 upper bits ignored
    {8'hFC, 1'b1, 32'hA5A5A5A5,  32'h0},
    {8'hFC, 1'b0, 32'h0,         32'hA5A5A5A5},  // R4 top word
    {8'hC3, 1'b1, 32'h00000011,  32'h0},
    {8'hC0, 1'b0, 32'h0,         32'h00000011},  // R4 low bits ignored
    {8'h7C, 1'b1, 32'h000000A9,  32'h0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hc_keyreg_top #(.VENDOR_ID(VEND)) i_hc_keyreg_top (
    .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata)
  );

  task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d);
    addr = a; we = w; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R6 rdata in reset", rdata, 32'h0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][72:65], VEC[i][64], VEC[i][63:32]);
      if (!VEC[i][64]) chk($sformatf("R1-table vec %0d", i), rdata, VEC[i][31:0]);
    end
    // bank locked again by entry 24
    step(8'h7C, 1'b0, 32'h0);
    chk("R2 relock by A9", rdata, 32'h0);
    step(8'h7C, 1'b1, 32'h000000A8);
    step(8'h08, 1'b1, 32'h00000055);
    chk("R5 read during write returns old", rdata, 32'hDEADBEEF);
    step(8'h08, 1'b0, 32'h0);
    chk("R4 new value after write", rdata, 32'h00000055);
    step(8'h7C, 1'b1, 32'h0);
    step(8'h7C, 1'b0, 32'h0);
    chk("R2 any other byte locks", rdata, 32'h0);
    // reset in the middle of a run
    step(8'h7C, 1'b1, 32'h000000A8);
    rst = 1'b1;
    step(8'h08, 1'b0, 32'h0);
    step(8'h08, 1'b0, 32'h0);
    chk("R6 rdata zero in mid reset", rdata, 32'h0);
    rst = 1'b0;
    step(8'h08, 1'b0, 32'h0);
    chk("R6 word restored to zero", rdata, 32'h0);
    step(8'h00, 1'b0, 32'h0);
    chk("R1 id restored", rdata, ID_RST);
    step(8'hC0, 1'b0, 32'h0);
    chk("R1 link status restored", rdata, 32'h00000020);
    step(8'h7C, 1'b0, 32'h0);
    chk("R3 locked after reset", rdata, 32'h0);
    step(8'h00, 1'b1, 32'hFFFFFFFF);
    step(8'h00, 1'b0, 32'h0);
    chk("R3 locked write to id ignored", rdata, ID_RST);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule